// File: doc/BRIEF.md
# Vectorized Sub-Block Window Assembler

This block sits between a memory read path and a sub-pixel interpolator. Reference pixels are kept in memory one 4x4 luma sub-block at a time: the sixteen bytes of a sub-block fill two neighbouring 64-bit words. One burst delivers eight words, which is four sub-blocks side by side, so a burst covers a strip 16 pixels wide and 4 pixels tall. The assembler takes a request that names the window shape, the window's starting row and column inside the returned strip, and the number of bursts to expect. It then stores the arriving words and rebuilds the rectangular window as a flat pixel array.

Bursts stack downward: the first burst is the top sub-block row and later ones lie below it. The window is 4 or 9 pixels wide and 4 or 9 pixels tall, as the interpolator needs for integer, horizontal half-pel, vertical half-pel or centre/quarter positions. The window may start at any pixel. Any window pixel that falls outside the captured data is returned as zero and raises an error flag. The control path is a three-state machine. IDLE accepts a request, going to FILL, or straight to EMIT when no bursts are expected. FILL stores beats and moves to EMIT on the last beat of the last expected burst. EMIT presents the window for one cycle and returns to IDLE.

Top module: `vec_window_asm`

## Requirements
- R1: After reset, req_ready is 1, win_valid is 0, and win_pix and win_err are zero. win_pix and win_err stay zero whenever win_valid is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the cycle after the window cycle, and is 1 again in that cycle.
- R3: Beat k (0..7) of a burst holds sub-block k>>1 of the strip. Even beats carry sub-block rows 0-1 and odd beats carry rows 2-3. Byte j (bits 8j+7..8j) holds sub-block row j>>2 of that pair and column j&3.
- R4: Burst b (0-based, in arrival order) supplies pixel rows 4b..4b+3 of the captured region.
- R5: Window pixel (r,c) is taken from captured-region row req_row+r and column req_col+c. req_row is 0..3 and req_col is 0..15, where req_col bits 3:2 name the sub-block and bits 1:0 name the pixel.
- R6: req_mode bit 0 makes the window 9 columns wide, otherwise 4. Bit 1 makes it 9 rows tall, otherwise 4. Pixel (r,c) appears at win_pix[(r*9+c)*8 +: 8], and every position outside the window's size is zero.
- R7: win_valid is high for exactly one cycle. That cycle follows the edge that takes the last beat of the last expected burst, or follows acceptance when req_bursts is 0.
- R8: A window pixel whose row is at or beyond 4*req_bursts, or whose column is 16 or more, is output as zero, and win_err is 1. If no such pixel exists, win_err is 0.
- R9: beat_valid while no request is pending has no effect. It neither counts toward a later request nor alters its data.
- R10: Data captured for an earlier request is never used for a later one. Rows that the later request did not receive read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Ready to accept a request |
| req_mode | input | 2 | Window shape: bit 0 wide, bit 1 tall |
| req_col | input | 4 | Window start column within the strip |
| req_row | input | 2 | Window start row within the first sub-block row |
| req_bursts | input | 2 | Number of bursts to expect (0..3) |
| beat_valid | input | 1 | Memory word strobe |
| beat_data | input | 64 | Memory word |
| win_valid | output | 1 | Window output strobe |
| win_err | output | 1 | Window holds uncovered positions |
| win_pix | output | 648 | 9x9 window, 8 bits per pixel, row-major |

## Verification
The hardest case to reach is a window that is only partly covered. This happens when a 9-row window starts at row 3 and fewer than three bursts come back, or when a 9-column window starts past column 7. The uncovered part must be zero and must not hold bytes left over from a previous, larger request. The stimulus reaches it by running a full three-burst 9x9 request first, then a one-burst 9x9 request from a different pixel seed, and comparing every position. Idle beats sent before a request show that stray words neither shorten the fill nor corrupt the stored data.

// File: rtl/win_asm_pkg.sv
package win_asm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2
    } win_state_t;

    // Window shape field: bit 0 widens columns to 9, bit 1 extends rows to 9
    typedef enum logic [1:0] {
        SHAPE_SQUARE4 = 2'b00,
        SHAPE_WIDE    = 2'b01,
        SHAPE_TALL    = 2'b10,
        SHAPE_FULL    = 2'b11
    } win_shape_t;

endpackage

// File: rtl/win_capture.sv
module win_capture #(
    parameter int PIX_W        = 8,
    parameter int SB           = 4,
    parameter int SB_PER_BURST = 4,
    parameter int MAX_SBROWS   = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   clear,
    input  logic                                   wr_en,
    input  logic [PIX_W*SB*SB/2-1:0]               wr_data,
    output logic [MAX_SBROWS*SB_PER_BURST*2*PIX_W*SB*SB/2-1:0] buf_flat,
    output logic [$clog2(MAX_SBROWS+1)-1:0]        rows_got,
    output logic                                   beat_last
);
    localparam int WORD_W = PIX_W * SB * SB / 2;
    localparam int BEATS  = SB_PER_BURST * 2;
    localparam int NWORDS = MAX_SBROWS * BEATS;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int CNT_W  = $clog2(MAX_SBROWS + 1);

    logic [BEAT_W-1:0] beat_cnt;
    logic              full;
    int unsigned       wr_sel;

    assign full      = (int'(rows_got) >= MAX_SBROWS);
    assign beat_last = wr_en && (int'(beat_cnt) == BEATS - 1);
    assign wr_sel    = int'(rows_got) * BEATS + int'(beat_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
            rows_got <= '0;
        end else if (clear) begin
            beat_cnt <= '0;
            rows_got <= '0;
        end else if (wr_en) begin
            if (int'(beat_cnt) == BEATS - 1) begin
                beat_cnt <= '0;
                if (!full) begin
                    rows_got <= rows_got + CNT_W'(1);
                end
            end else begin
                beat_cnt <= beat_cnt + BEAT_W'(1);
            end
        end
    end

    // Word storage: coverage comes from rows_got, so contents need no reset
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (wr_en && !full && (wr_sel == w)) begin
                word_q <= wr_data;
            end
        end
        assign buf_flat[w*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/win_extract.sv
module win_extract #(
    parameter int PIX_W        = 8,
    parameter int SB           = 4,
    parameter int SB_PER_BURST = 4,
    parameter int MAX_SBROWS   = 3,
    parameter int WIN          = 9
) (
    input  logic [MAX_SBROWS*SB_PER_BURST*2*PIX_W*SB*SB/2-1:0] buf_flat,
    input  logic [$clog2(MAX_SBROWS+1)-1:0]        rows_got,
    input  logic [1:0]                             shape,
    input  logic [$clog2(SB_PER_BURST*SB)-1:0]     col0,
    input  logic [$clog2(SB)-1:0]                  row0,
    output logic [WIN*WIN*PIX_W-1:0]               pix_flat,
    output logic                                   miss_any
);
    localparam int WORD_W = PIX_W * SB * SB / 2;
    localparam int BEATS  = SB_PER_BURST * 2;
    localparam int SPAN_X = SB_PER_BURST * SB;
    localparam int BUF_W  = MAX_SBROWS * BEATS * WORD_W;
    localparam int IDX_W  = $clog2(BUF_W);
    localparam int HALF   = SB / 2;

    int unsigned rows_n;
    int unsigned cols_n;
    int unsigned rows_cov;
    logic [WIN*WIN-1:0] miss;

    assign rows_n   = shape[1] ? WIN : SB;
    assign cols_n   = shape[0] ? WIN : SB;
    assign rows_cov = SB * int'(rows_got);
    assign miss_any = |miss;

    for (genvar gr = 0; gr < WIN; gr++) begin : g_row
        for (genvar gc = 0; gc < WIN; gc++) begin : g_col
            int unsigned ar;
            int unsigned ac;
            int unsigned wi;
            int unsigned bo;
            logic        in_win;
            logic        cov;
            logic [IDX_W-1:0] idx;

            always_comb begin
                ar     = int'(row0) + gr;
                ac     = int'(col0) + gc;
                in_win = (gr < rows_n) && (gc < cols_n);
                cov    = (ac < SPAN_X) && (ar < rows_cov);
                // sub-block row, sub-block in strip, upper/lower word
                wi     = (ar / SB) * BEATS + (ac / SB) * 2 + (ar % SB) / HALF;
                bo     = (ar % HALF) * SB + (ac % SB);
                idx    = cov ? IDX_W'(wi * WORD_W + bo * PIX_W) : '0;
            end

            assign pix_flat[(gr*WIN+gc)*PIX_W +: PIX_W] =
                (in_win && cov) ? buf_flat[idx +: PIX_W] : '0;
            assign miss[gr*WIN+gc] = in_win && !cov;
        end
    end

endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
    import win_asm_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 2,
    parameter int BW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic [COL_W-1:0] req_col,
    input  logic [ROW_W-1:0] req_row,
    input  logic [BW-1:0]    req_bursts,
    input  logic             beat_last,
    input  logic [BW-1:0]    rows_got,
    output logic             req_ready,
    output logic             cap_clear,
    output logic             cap_en,
    output logic             emit,
    output logic [1:0]       cur_mode,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row,
    output logic [BW-1:0]    cur_bursts
);
    win_state_t state_q, state_d;
    logic       accept;
    logic       fill_done;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign fill_done = beat_last &&
                       (({1'b0, rows_got} + (BW+1)'(1)) >= {1'b0, cur_bursts});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request parameters held for the whole transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode   <= '0;
            cur_col    <= '0;
            cur_row    <= '0;
            cur_bursts <= '0;
        end else if (accept) begin
            cur_mode   <= req_mode;
            cur_col    <= req_col;
            cur_row    <= req_row;
            cur_bursts <= req_bursts;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_bursts == '0) ? ST_EMIT : ST_FILL;
                end
            end
            ST_FILL: begin
                if (fill_done) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        cap_clear = 1'b0;
        cap_en    = 1'b0;
        emit      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cap_clear = req_valid;
            end
            ST_FILL: cap_en = 1'b1;
            ST_EMIT: emit   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vec_window_asm.sv
module vec_window_asm #(
    parameter int PIX_W        = 8,
    parameter int SB           = 4,
    parameter int SB_PER_BURST = 4,
    parameter int MAX_SBROWS   = 3,
    parameter int WIN          = 9
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [1:0]                            req_mode,
    input  logic [$clog2(SB_PER_BURST*SB)-1:0]    req_col,
    input  logic [$clog2(SB)-1:0]                 req_row,
    input  logic [$clog2(MAX_SBROWS+1)-1:0]       req_bursts,
    input  logic                                  beat_valid,
    input  logic [PIX_W*SB*SB/2-1:0]              beat_data,
    output logic                                  win_valid,
    output logic                                  win_err,
    output logic [WIN*WIN*PIX_W-1:0]              win_pix
);
    localparam int WORD_W = PIX_W * SB * SB / 2;
    localparam int BEATS  = SB_PER_BURST * 2;
    localparam int BUF_W  = MAX_SBROWS * BEATS * WORD_W;
    localparam int COL_W  = $clog2(SB_PER_BURST * SB);
    localparam int ROW_W  = $clog2(SB);
    localparam int BW     = $clog2(MAX_SBROWS + 1);

    logic             cap_clear;
    logic             cap_en;
    logic             wr_en;
    logic             beat_last;
    logic             emit;
    logic [BW-1:0]    rows_got;
    logic [BUF_W-1:0] buf_flat;
    logic [1:0]       cur_mode;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    logic [BW-1:0]    cur_bursts;
    logic [WIN*WIN*PIX_W-1:0] ext_pix;
    logic             ext_miss;

    assign wr_en = cap_en && beat_valid;

    win_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W), .BW(BW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_col    (req_col),
        .req_row    (req_row),
        .req_bursts (req_bursts),
        .beat_last  (beat_last),
        .rows_got   (rows_got),
        .req_ready  (req_ready),
        .cap_clear  (cap_clear),
        .cap_en     (cap_en),
        .emit       (emit),
        .cur_mode   (cur_mode),
        .cur_col    (cur_col),
        .cur_row    (cur_row),
        .cur_bursts (cur_bursts)
    );

    win_capture #(
        .PIX_W(PIX_W), .SB(SB), .SB_PER_BURST(SB_PER_BURST), .MAX_SBROWS(MAX_SBROWS)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cap_clear),
        .wr_en     (wr_en),
        .wr_data   (beat_data),
        .buf_flat  (buf_flat),
        .rows_got  (rows_got),
        .beat_last (beat_last)
    );

    win_extract #(
        .PIX_W(PIX_W), .SB(SB), .SB_PER_BURST(SB_PER_BURST),
        .MAX_SBROWS(MAX_SBROWS), .WIN(WIN)
    ) u_ext (
        .buf_flat (buf_flat),
        .rows_got (rows_got),
        .shape    (cur_mode),
        .col0     (cur_col),
        .row0     (cur_row),
        .pix_flat (ext_pix),
        .miss_any (ext_miss)
    );

    assign win_valid = emit;
    assign win_err   = emit && ext_miss;
    assign win_pix   = emit ? ext_pix : '0;

endmodule

// File: rtl/win_asm_checker.sv
module win_asm_checker #(
    parameter int PIX_W = 8,
    parameter int WIN   = 9,
    parameter int BW    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [BW-1:0]            req_bursts,
    input logic                     win_valid,
    input logic                     win_err,
    input logic [WIN*WIN*PIX_W-1:0] win_pix,
    input logic [1:0]               cur_mode,
    input logic [BW-1:0]            cur_bursts
);
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_ready_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> req_ready);

    a_r2_not_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !req_ready);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);

    a_r7_zero_burst_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_bursts == '0)) |=> win_valid);

    a_r6_narrow_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !cur_mode[0]) |-> (win_pix[4*PIX_W +: PIX_W] == '0));

    a_r6_short_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !cur_mode[1]) |-> (win_pix[4*WIN*PIX_W +: PIX_W] == '0));

    a_r8_no_rows_error: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && (cur_bursts == '0)) |-> win_err);

endmodule

bind vec_window_asm win_asm_checker #(.PIX_W(PIX_W), .WIN(WIN), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_bursts (req_bursts),
    .win_valid  (win_valid),
    .win_err    (win_err),
    .win_pix    (win_pix),
    .cur_mode   (cur_mode),
    .cur_bursts (cur_bursts)
);

// File: tb/vec_window_asm_tb.sv
`timescale 1ns/1ps
module vec_window_asm_tb;
    localparam int PIX_W  = 8;
    localparam int WIN    = 9;
    localparam int WORD_W = 64;
    localparam int SPAN   = 16;
    localparam int PIX_BITS = WIN * WIN * PIX_W;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid;
    logic req_ready;
    logic [1:0] req_mode;
    logic [3:0] req_col;
    logic [1:0] req_row;
    logic [1:0] req_bursts;
    logic beat_valid;
    logic [WORD_W-1:0] beat_data;
    logic win_valid;
    logic win_err;
    logic [PIX_BITS-1:0] win_pix;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    vec_window_asm u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_col(req_col), .req_row(req_row),
        .req_bursts(req_bursts),
        .beat_valid(beat_valid), .beat_data(beat_data),
        .win_valid(win_valid), .win_err(win_err), .win_pix(win_pix)
    );

    task automatic chk(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [7:0] pixv(input int seed, input int r, input int c);
        return 8'((r * 16 + c + seed + 1) % 256);
    endfunction

    // R3 layout: beat w -> sub-block w>>1, rows 2*(w&1)+(j>>2), column j&3
    function automatic logic [WORD_W-1:0] mkword(input int seed, input int b, input int w);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int j = 0; j < 8; j++) begin
            v[j*8 +: 8] = pixv(seed, b*4 + (w%2)*2 + j/4, (w/2)*4 + j%4);
        end
        return v;
    endfunction

    task automatic run_req(input int mode, input int x0, input int y0, input int nb,
                           input int seed, input string tag);
        logic [PIX_BITS-1:0] expv;
        bit expe;
        int rn, cn;
        rn = (mode / 2 == 1) ? 9 : 4;
        cn = (mode % 2 == 1) ? 9 : 4;
        expv = '0;
        expe = 1'b0;
        for (int r = 0; r < WIN; r++) begin
            for (int c = 0; c < WIN; c++) begin
                if (r < rn && c < cn) begin
                    if ((x0 + c) < SPAN && (y0 + r) < 4 * nb)
                        expv[(r*WIN+c)*8 +: 8] = pixv(seed, y0 + r, x0 + c);
                    else
                        expe = 1'b1;
                end
            end
        end
        @(negedge clk);
        chk(req_ready == 1'b1, $sformatf("R2 %s ready before request act=%0b exp=1", tag, req_ready));
        req_valid  = 1'b1;
        req_mode   = 2'(mode);
        req_col    = 4'(x0);
        req_row    = 2'(y0);
        req_bursts = 2'(nb);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, $sformatf("R2 %s busy after accept act=%0b exp=0", tag, req_ready));
        for (int b = 0; b < nb; b++) begin
            for (int w = 0; w < 8; w++) begin
                @(negedge clk);
                if (b == nb - 1 && w == 7)
                    chk(win_valid == 1'b0, $sformatf("R7 %s early window act=%0b exp=0", tag, win_valid));
                beat_valid = 1'b1;
                beat_data  = mkword(seed, b, w);
            end
        end
        if (nb > 0) begin
            @(negedge clk);
            beat_valid = 1'b0;
            beat_data  = '0;
        end
        chk(win_valid == 1'b1, $sformatf("R7 %s window strobe act=%0b exp=1", tag, win_valid));
        chk(win_pix == expv, $sformatf("R5 R6 R8 %s pixels act=%h exp=%h", tag, win_pix, expv));
        chk(win_err == expe, $sformatf("R8 %s error flag act=%0b exp=%0b", tag, win_err, expe));
        chk(req_ready == 1'b0, $sformatf("R2 %s ready in window act=%0b exp=0", tag, req_ready));
        @(negedge clk);
        chk(win_valid == 1'b0, $sformatf("R7 %s strobe width act=%0b exp=0", tag, win_valid));
        chk(win_pix == '0 && win_err == 1'b0,
            $sformatf("R1 %s quiet outputs act=%0b/%0b exp=0", tag, |win_pix, win_err));
        chk(req_ready == 1'b1, $sformatf("R2 %s ready again act=%0b exp=1", tag, req_ready));
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1 && win_valid == 1'b0,
            $sformatf("R1 reset handshake act=%0b%0b exp=10", req_ready, win_valid));
        chk(win_pix == '0 && win_err == 1'b0,
            $sformatf("R1 reset outputs act=%0b%0b exp=00", |win_pix, win_err));
    endtask

    // R9: stray beats in IDLE must not count or corrupt
    task automatic t_idle_beats();
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            beat_valid = 1'b1;
            beat_data  = mkword(55, 0, w);
        end
        @(negedge clk);
        beat_valid = 1'b0;
        chk(win_valid == 1'b0 && req_ready == 1'b1,
            $sformatf("R9 idle beats act=%0b%0b exp=01", win_valid, req_ready));
        run_req(0, 0, 0, 1, 21, "R9 after idle beats");
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_mode = '0; req_col = '0; req_row = '0; req_bursts = '0;
        beat_valid = 1'b0; beat_data = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_req(0, 0, 0, 1, 3, "R3 aligned 4x4");
        run_req(0, 5, 3, 2, 7, "R4 offset 4x4 over two rows");
        run_req(1, 6, 1, 1, 11, "R6 wide window");
        run_req(2, 9, 2, 3, 13, "R6 tall window");
        run_req(3, 7, 3, 3, 17, "R5 full window");
        run_req(3, 0, 0, 1, 29, "R10 short after full");
        run_req(1, 10, 0, 1, 31, "R8 column overflow");
        run_req(3, 2, 1, 0, 0, "R8 R7 zero bursts");
        t_idle_beats();
        run_req(2, 15, 3, 2, 40, "R8 R10 last column");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule